// File: doc/BRIEF.md
# Two-Level Translation Walker

This block resolves a translation miss for a 32-bit virtual address that uses 4 KB pages. It takes one request at a time and reads two 4-byte entries through a single 32-bit memory read/write port. The first is a directory entry, found from a directory base input and the top ten address bits. The second is a table entry, found from the directory entry's frame number and the next ten address bits. While it walks, it sets the accessed flag, and on writes the dirty flag, by writing the entry back to memory. It checks presence and access rights. It then finishes with a one-cycle completion pulse that carries either a fill for the translation cache or a fault record.

The fault record gives a cause code together with the virtual address, the access type and the privilege level of the request. Both levels must grant a right for it to hold: writability and user access are each the AND of the matching bits of the two entries. A directory entry that marks a large page is rejected, because only 4 KB pages are handled.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every walk ends with `done` high for exactly one cycle, and `req_ready` is high again in the next cycle.
- R2: The first read of a walk goes to address `dir_base + 4*vaddr[31:22]`.
- R3: The table entry is read from `{pde[31:12], 12'h000} + 4*vaddr[21:12]`.
- R4: If bit 0 (present) of either entry is 0, the walk ends with `fault` high and `fault_cause` = 2'b01. An entry that is not present is never written back.
- R5: If a present directory entry has bit 7 (large page) set, the walk ends with `fault_cause` = 2'b11. Nothing is written to memory and no table entry is read.
- R6: Effective writability is bit 1 of both entries ANDed. Effective user access is bit 2 of both entries ANDed. A user access needs user access. A write needs writability, in supervisor mode too when `SUP_WRITE_PROTECT`=1. Otherwise the walk ends with `fault_cause` = 2'b10 and the table entry is not written.
- R7: The accessed flag is bit 5. A present, small-page directory entry whose bit 5 is clear is written back once, with bit 5 set and all other bits unchanged. The same holds for a table entry that passes the checks. Each write-back goes to the address just read, and an entry whose bit 5 is already set is not written for that flag.
- R8: On a write walk that succeeds, the table entry is written with bit 6 (dirty) set if that bit was clear.
- R9: A walk that succeeds pulses `fill_ok` with `done`, and `fault_cause` is 2'b00. `fill_ppn` = pte[31:12] and `fill_global` = pte bit 8. `fill_writable` and `fill_user` carry the effective rights, and `fill_dirty` carries the table entry's dirty flag after the update. Every write-back finishes before `done`.
- R10: While `done` is high, `res_vaddr`, `res_write` and `res_user` hold the address, access type and privilege of the request that was taken.
- R11: Once `mem_req` is raised it stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| dir_base | input | 32 | Physical base of the page directory |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Entry write-back data |
| mem_ack | input | 1 | Access complete (read data valid) |
| mem_rdata | input | 32 | Entry read data |
| done | output | 1 | One-cycle completion pulse |
| fill_ok | output | 1 | Completion with a valid fill |
| fault | output | 1 | Completion with a fault |
| fault_cause | output | 2 | 00 none, 01 not present, 10 protection, 11 large page |
| res_vaddr | output | 32 | Virtual address of the finished walk |
| res_write | output | 1 | Access type of the finished walk |
| res_user | output | 1 | Privilege of the finished walk |
| fill_ppn | output | 20 | Physical frame number |
| fill_writable | output | 1 | Effective write right |
| fill_user | output | 1 | Effective user right |
| fill_global | output | 1 | Global flag of the table entry |
| fill_dirty | output | 1 | Dirty flag after update |

## Verification
Random entry pairs are built at random directory and table indices. Each entry gets random presence, large-page, rights and flag bits, and each request a random access type and privilege, so all three fault causes and both kinds of write-back come out of one stream. The memory model adds a random 0 to 2 cycle delay and logs every address. This tells a wrong index or frame field apart from a wrong outcome, and a missing write-back apart from a needless one. Directed pairs then pin down single cases that random draws may miss: accessed already set with no write at all, a supervisor write to a directory marked read-only, a user read of a supervisor page that still writes back the directory entry, and a global page.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int unsigned BIT_P   = 0;
   localparam int unsigned BIT_RW  = 1;
   localparam int unsigned BIT_US  = 2;
   localparam int unsigned BIT_ACC = 5;
   localparam int unsigned BIT_DTY = 6;
   localparam int unsigned BIT_LRG = 7;
   localparam int unsigned BIT_GLB = 8;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'b00,
      CAUSE_ABSENT = 2'b01,
      CAUSE_PROT   = 2'b10,
      CAUSE_LARGE  = 2'b11
   } cause_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_DIR, ST_WB_DIR, ST_RD_TBL, ST_WB_TBL, ST_DONE
   } walk_st_e;
endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
   parameter int AW     = 32,
   parameter int IDX_W  = 10,
   parameter int OFF_W  = 12,
   parameter int ENT_LG = 2
) (
   input  logic [AW-1:0] dir_base,
   input  logic [AW-1:0] vaddr,
   input  logic [AW-1:0] dir_entry,
   output logic [AW-1:0] dir_addr,
   output logic [AW-1:0] tbl_addr
);
   localparam int PAD_W = AW - IDX_W - ENT_LG;

   logic [IDX_W-1:0] dir_idx, tbl_idx;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("xlat_addr_gen: index too wide for address");
      end
   endgenerate

   assign dir_idx  = vaddr[AW-1 -: IDX_W];
   assign tbl_idx  = vaddr[OFF_W +: IDX_W];
   assign dir_addr = dir_base + {{PAD_W{1'b0}}, dir_idx, {ENT_LG{1'b0}}};
   assign tbl_addr = {dir_entry[AW-1:OFF_W], {OFF_W{1'b0}}}
                   + {{PAD_W{1'b0}}, tbl_idx, {ENT_LG{1'b0}}};
endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check #(
   parameter int AW                = 32,
   parameter bit SUP_WRITE_PROTECT = 1'b1
) (
   input  logic [AW-1:0] dir_entry,
   input  logic [AW-1:0] tbl_entry,
   input  logic          is_write,
   input  logic          is_user,
   output logic          eff_wr,
   output logic          eff_us,
   output logic          violation
);
   import xlat_pkg::*;

   logic wr_bad, us_bad;

   assign eff_wr = dir_entry[BIT_RW] & tbl_entry[BIT_RW];
   assign eff_us = dir_entry[BIT_US] & tbl_entry[BIT_US];
   assign us_bad = is_user & ~eff_us;

   generate
      if (SUP_WRITE_PROTECT) begin : g_wp_all
         assign wr_bad = is_write & ~eff_wr;
      end else begin : g_wp_user
         assign wr_bad = is_write & is_user & ~eff_wr;
      end
   endgenerate

   assign violation = wr_bad | us_bad;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
   parameter int AW                = 32,
   parameter int IDX_W             = 10,
   parameter int OFF_W             = 12,
   parameter bit SUP_WRITE_PROTECT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [AW-1:0]      req_vaddr,
   input  logic               req_write,
   input  logic               req_user,
   input  logic [AW-1:0]      dir_base,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [AW-1:0]      mem_wdata,
   input  logic               mem_ack,
   input  logic [AW-1:0]      mem_rdata,
   output logic               done,
   output logic               fill_ok,
   output logic               fault,
   output logic [1:0]         fault_cause,
   output logic [AW-1:0]      res_vaddr,
   output logic               res_write,
   output logic               res_user,
   output logic [AW-OFF_W-1:0] fill_ppn,
   output logic               fill_writable,
   output logic               fill_user,
   output logic               fill_global,
   output logic               fill_dirty
);
   import xlat_pkg::*;

   localparam int PPN_W = AW - OFF_W;

   generate
      if (AW != 2 * IDX_W + OFF_W) begin : g_bad_split
         $error("xlat_walker: AW must equal 2*IDX_W+OFF_W");
      end
      if (OFF_W <= BIT_GLB) begin : g_bad_off
         $error("xlat_walker: offset too narrow for flag bits");
      end
   endgenerate

   walk_st_e          st;
   logic [AW-1:0]     va_q, pde_q, pte_q;
   logic              wr_q, us_q;
   cause_e            cause_q;
   logic [PPN_W-1:0]  ppn_q;
   logic              fw_q, fu_q, fg_q, fd_q;
   logic [AW-1:0]     dir_addr, tbl_addr;
   logic              eff_wr, eff_us, violation;
   logic [AW-1:0]     acc_mask, dty_mask;
   logic              tbl_needs_wb;

   xlat_addr_gen #(.AW(AW), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_LG(2)) u_addr (
      .dir_base (dir_base),
      .vaddr    (va_q),
      .dir_entry(pde_q),
      .dir_addr (dir_addr),
      .tbl_addr (tbl_addr)
   );

   xlat_perm_check #(.AW(AW), .SUP_WRITE_PROTECT(SUP_WRITE_PROTECT)) u_perm (
      .dir_entry(pde_q),
      .tbl_entry(mem_rdata),
      .is_write (wr_q),
      .is_user  (us_q),
      .eff_wr   (eff_wr),
      .eff_us   (eff_us),
      .violation(violation)
   );

   always_comb begin
      acc_mask          = '0;
      acc_mask[BIT_ACC] = 1'b1;
      dty_mask          = '0;
      dty_mask[BIT_DTY] = wr_q;
   end

   assign tbl_needs_wb = ~mem_rdata[BIT_ACC] | (wr_q & ~mem_rdata[BIT_DTY]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         us_q    <= 1'b0;
         pde_q   <= '0;
         pte_q   <= '0;
         cause_q <= CAUSE_NONE;
         ppn_q   <= '0;
         fw_q    <= 1'b0;
         fu_q    <= 1'b0;
         fg_q    <= 1'b0;
         fd_q    <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               va_q <= req_vaddr;
               wr_q <= req_write;
               us_q <= req_user;
               st   <= ST_RD_DIR;
            end
            ST_RD_DIR: if (mem_ack) begin
               pde_q <= mem_rdata;
               if (!mem_rdata[BIT_P]) begin
                  cause_q <= CAUSE_ABSENT;
                  st      <= ST_DONE;
               end else if (mem_rdata[BIT_LRG]) begin
                  cause_q <= CAUSE_LARGE;
                  st      <= ST_DONE;
               end else if (!mem_rdata[BIT_ACC]) begin
                  st <= ST_WB_DIR;
               end else begin
                  st <= ST_RD_TBL;
               end
            end
            ST_WB_DIR: if (mem_ack) st <= ST_RD_TBL;
            ST_RD_TBL: if (mem_ack) begin
               pte_q <= mem_rdata;
               if (!mem_rdata[BIT_P]) begin
                  cause_q <= CAUSE_ABSENT;
                  st      <= ST_DONE;
               end else if (violation) begin
                  cause_q <= CAUSE_PROT;
                  st      <= ST_DONE;
               end else begin
                  cause_q <= CAUSE_NONE;
                  ppn_q   <= mem_rdata[AW-1:OFF_W];
                  fw_q    <= eff_wr;
                  fu_q    <= eff_us;
                  fg_q    <= mem_rdata[BIT_GLB];
                  fd_q    <= mem_rdata[BIT_DTY] | wr_q;
                  st      <= tbl_needs_wb ? ST_WB_TBL : ST_DONE;
               end
            end
            ST_WB_TBL: if (mem_ack) st <= ST_DONE;
            ST_DONE:   st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (st == ST_RD_DIR) || (st == ST_WB_DIR) || (st == ST_RD_TBL) || (st == ST_WB_TBL);
      mem_we    = (st == ST_WB_DIR) || (st == ST_WB_TBL);
      mem_addr  = ((st == ST_RD_DIR) || (st == ST_WB_DIR)) ? dir_addr : tbl_addr;
      mem_wdata = (st == ST_WB_DIR) ? (pde_q | acc_mask) : (pte_q | acc_mask | dty_mask);
   end

   assign req_ready     = (st == ST_IDLE);
   assign done          = (st == ST_DONE);
   assign fault         = done && (cause_q != CAUSE_NONE);
   assign fill_ok       = done && (cause_q == CAUSE_NONE);
   assign fault_cause   = cause_q;
   assign res_vaddr     = va_q;
   assign res_write     = wr_q;
   assign res_user      = us_q;
   assign fill_ppn      = ppn_q;
   assign fill_writable = fw_q;
   assign fill_user     = fu_q;
   assign fill_global   = fg_q;
   assign fill_dirty    = fd_q;

   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && req_ready);

   assert_take_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready && mem_req && !mem_we);

   assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   assert_wb_sets_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[BIT_ACC]);

   assert_wb_same_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $stable(mem_addr) && $past(mem_ack));

   assert_dirty_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_ok && res_write |-> fill_dirty);

   assert_user_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_ok && res_user |-> fill_user);

   assert_cause_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fault_cause == 2'b00) == fill_ok);
endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [31:0] dir_base = 32'h0000_1000;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done, fill_ok, fault;
   logic [1:0]  fault_cause;
   logic [31:0] res_vaddr;
   logic        res_write, res_user;
   logic [19:0] fill_ppn;
   logic        fill_writable, fill_user, fill_global, fill_dirty;

   int checks = 0;
   int fails  = 0;

   xlat_walker uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .done(done), .fill_ok(fill_ok), .fault(fault), .fault_cause(fault_cause),
      .res_vaddr(res_vaddr), .res_write(res_write), .res_user(res_user),
      .fill_ppn(fill_ppn), .fill_writable(fill_writable), .fill_user(fill_user),
      .fill_global(fill_global), .fill_dirty(fill_dirty)
   );

   always #2 clk = ~clk;

   logic [31:0] mem [0:8191];
   int          wr_cnt = 0;
   int          rd_cnt = 0;
   int          hold_err = 0;
   logic [31:0] rd_log [0:1];
   logic [31:0] hold_addr = '0;
   bit          holding = 1'b0;
   int          wait_n = 0;

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         holding = 1'b0;
      end else if (mem_req) begin
         if (!holding) begin
            holding   = 1'b1;
            hold_addr = mem_addr;
            wait_n    = int'($urandom % 3);
         end else if (mem_addr != hold_addr) begin
            hold_err++;
         end
         if (wait_n == 0) begin
            mem_ack = 1'b1;
            if (mem_we) begin
               mem[mem_addr[14:2]] = mem_wdata;
               wr_cnt++;
            end else begin
               mem_rdata = mem[mem_addr[14:2]];
               if (rd_cnt < 2) rd_log[rd_cnt] = mem_addr;
               rd_cnt++;
            end
         end else begin
            wait_n--;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_walk(input logic [31:0] va, input logic w, input logic u);
      logic [31:0] pde_a, pte_a, pde, pte, exp_pde, exp_pte;
      logic [1:0]  cause;
      logic        ew, eu, viol;
      int          exp_wr, exp_rd, guard;
      pde_a   = dir_base + {20'd0, va[31:22], 2'b00};
      pde     = mem[pde_a[14:2]];
      exp_pde = pde;
      pte_a   = {pde[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
      pte     = mem[pte_a[14:2]];
      exp_pte = pte;
      ew = 1'b0; eu = 1'b0;
      exp_rd = 1;
      if (!pde[0]) cause = 2'b01;
      else if (pde[7]) cause = 2'b11;
      else begin
         exp_rd  = 2;
         exp_pde = pde | 32'h20;
         if (!pte[0]) cause = 2'b01;
         else begin
            ew   = pde[1] & pte[1];
            eu   = pde[2] & pte[2];
            viol = (w & ~ew) | (u & ~eu);
            if (viol) cause = 2'b10;
            else begin
               cause   = 2'b00;
               exp_pte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
            end
         end
      end
      exp_wr = int'(exp_pde != pde) + int'(exp_pte != pte);

      wr_cnt = 0; rd_cnt = 0; hold_err = 0;
      @(negedge clk);
      req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      guard = 0;
      while (!done && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      chk(done == 1'b1, "R1 done pulse", {31'd0, done}, 32'd1);
      chk(fault_cause == cause, "R4 R5 R6 R9 cause", {30'd0, fault_cause}, {30'd0, cause});
      chk(fault == (cause != 2'b00) && fill_ok == (cause == 2'b00), "R9 fault/fill flags",
          {30'd0, fault, fill_ok}, {30'd0, cause != 2'b00, cause == 2'b00});
      chk(res_vaddr == va && res_write == w && res_user == u, "R10 record",
          res_vaddr ^ {30'd0, res_write ^ w, res_user ^ u}, va);
      chk(rd_log[0] == pde_a, "R2 directory address", rd_log[0], pde_a);
      if (exp_rd == 2) chk(rd_log[1] == pte_a, "R3 table address", rd_log[1], pte_a);
      chk(rd_cnt == exp_rd, "R5 R4 read count", rd_cnt, exp_rd);
      chk(mem[pde_a[14:2]] == exp_pde, "R7 directory entry in memory", mem[pde_a[14:2]], exp_pde);
      if (exp_rd == 2)
         chk(mem[pte_a[14:2]] == exp_pte, "R8 R7 table entry in memory", mem[pte_a[14:2]], exp_pte);
      chk(wr_cnt == exp_wr, "R7 R8 write-back count", wr_cnt, exp_wr);
      chk(hold_err == 0, "R11 request held", hold_err, 0);
      if (cause == 2'b00) begin
         chk(fill_ppn == pte[31:12], "R9 frame number", {12'd0, fill_ppn}, {12'd0, pte[31:12]});
         chk({fill_writable, fill_user, fill_global, fill_dirty} == {ew, eu, pte[8], pte[6] | w},
             "R9 fill flags", {28'd0, fill_writable, fill_user, fill_global, fill_dirty},
             {28'd0, ew, eu, pte[8], pte[6] | w});
      end
      @(negedge clk);
      chk(done == 1'b0 && req_ready == 1'b1, "R1 ready after done", {30'd0, done, req_ready}, 32'd1);
   endtask

   task automatic set_pair(input logic [31:0] va, input logic [31:0] pde, input logic [31:0] pte);
      logic [31:0] pa, ta;
      pa = dir_base + {20'd0, va[31:22], 2'b00};
      mem[pa[14:2]] = pde;
      ta = {pde[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
      if (ta < 32'h8000) mem[ta[14:2]] = pte;
   endtask

   initial begin
      void'($urandom(32'd20515));
      for (int i = 0; i < 8192; i++) mem[i] = $urandom;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && done == 1'b0 && mem_req == 1'b0, "R1 reset state",
          {29'd0, req_ready, done, mem_req}, 32'd4);

      set_pair(32'h0040_1123, 32'h0000_2006, 32'h0);          do_walk(32'h0040_1123, 1'b0, 1'b0); // R4 dir absent
      set_pair(32'h0080_2000, 32'h0000_2087, 32'h0);          do_walk(32'h0080_2000, 1'b0, 1'b0); // R5 large
      set_pair(32'h00C0_3000, 32'h0000_3027, 32'hABCD_E027); do_walk(32'h00C0_3000, 1'b0, 1'b1); // R7 no wb
      set_pair(32'h0100_4000, 32'h0000_4007, 32'h1234_5007); do_walk(32'h0100_4000, 1'b1, 1'b0); // R8 dirty
      set_pair(32'h0140_5000, 32'h0000_5007, 32'h0005_5003); do_walk(32'h0140_5000, 1'b0, 1'b1); // R6 user
      set_pair(32'h0180_6000, 32'h0000_6025, 32'h0006_6067); do_walk(32'h0180_6000, 1'b1, 1'b0); // R6 ro dir
      set_pair(32'h01C0_7000, 32'h0000_7027, 32'h0007_7006); do_walk(32'h01C0_7000, 1'b0, 1'b0); // R4 tbl absent
      set_pair(32'h0200_2000, 32'h0000_2027, 32'h0008_8167); do_walk(32'h0200_2000, 1'b0, 1'b0); // R9 global

      for (int n = 0; n < 400; n++) begin
         logic [31:0] va, pde, pte;
         va  = $urandom;
         pde = $urandom;
         pde[31:12] = 20'(2 + ($urandom % 6));
         pde[0] = ($urandom % 8) != 0;
         pde[7] = ($urandom % 10) == 0;
         pte = $urandom;
         pte[0] = ($urandom % 8) != 0;
         set_pair(va, pde, pte);
         do_walk(va, 1'($urandom), 1'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule